// File: doc/BRIEF.md
# Processor Machine-Cycle Sequencer

This block decides, one machine cycle at a time, which cycle a small 8-bit processor performs next. The cycle types are reset, initialize, fetch, execute, DMA-in, DMA-out and interrupt. The block also follows the external operating-mode pins, which select run, pause, load or reset. Each machine cycle takes one clock. For every cycle the sequencer presents the cycle type, a 2-bit state code for external decoding, and one-cycle strobes. The datapath uses these strobes to clear or set its registers, to latch the opcode, to step the DMA pointer and to save the interrupted context.

The datapath returns the interrupt-enable bit and, during a fetch cycle, the two opcode nibbles read from memory. The all-zero opcode is the idle instruction. After an idle instruction the sequencer stays in execute until a DMA or interrupt request wakes it. Every pin on this block is plain level control or status. No data stream passes through it, so it has no valid/ready handshake and no back-pressure rules.

The mode pins are sampled at every clock edge. The sequencer keeps its own notion of the current mode. That record makes a run request that arrives after load have no effect. It also decides whether a run request after reset starts with an initialize cycle, and whether a run request after pause resumes at fetch.

Top module: `mcycle_sequencer`

## Requirements
- R1: With mode_i = 3 (reset), the cycle after the edge is the reset cycle. In that cycle state_o = 0, state_code_o = 1 and regs_clr_o = 1, and regs_clr_o tells the datapath to clear the opcode nibbles and the flag output and to set interrupt enable. The block also enters this cycle while rst_n is low.
- R2: When mode_i changes to 0 (run) and the sequencer's own mode is reset, the next cycle is initialize. In that cycle state_o = 1, state_code_o = 1 and ptr_clr_o = 1, which clears the index selector, the counter selector and pointer register 0.
- R3: In run, a fetch cycle (state_o = 2, state_code_o = 0, op_load_o = 1) is always followed by execute (state_o = 3, state_code_o = 1, no strobe), whatever requests are present.
- R4: After an execute, DMA or interrupt cycle in run, the next cycle is chosen by fixed priority: DMA-in first, then DMA-out, then interrupt, then fetch. A request that stays asserted repeats its DMA cycle.
- R5: An execute cycle whose fetched opcode was 0x00 (both nibbles zero) repeats until a DMA request, or an interrupt request with ie_i = 1, arrives. Any other opcode, including 0x05 and 0x10, goes on to the next fetch.
- R6: A DMA-in cycle (state_o = 4) raises dma_wr_o and dma_ptr_inc_o. A DMA-out cycle (state_o = 5) raises dma_rd_o and dma_ptr_inc_o. Both DMA cycles report state_code_o = 2.
- R7: An interrupt cycle (state_o = 6, state_code_o = 3) raises ctx_save_o. That strobe tells the datapath to save the two selectors, point them at the interrupt registers and clear interrupt enable. The cycle is never followed by a second interrupt cycle: the next cycle is a DMA cycle if one is requested, otherwise fetch. An interrupt request is ignored while ie_i = 0.
- R8: With mode_i = 2 (load), the sequencer never fetches. It sits in execute, serves DMA and interrupt requests, and returns to execute after each of them.
- R9: A run request while the sequencer's own mode is load has no effect, and the block goes on behaving as in load. Run after pause resumes at fetch even when load preceded the pause.
- R10: With mode_i = 1 (pause), the state holds and every strobe is 0 for the following cycle. A later run request resumes at fetch with op_load_o = 1.
- R11: The initialize cycle arbitrates DMA-in and then DMA-out before the first fetch. It never goes to interrupt.
- R12: The state codes are fetch 0, execute, reset and initialize 1, either DMA cycle 2, and interrupt 3. At most one strobe is active, apart from dma_ptr_inc_o, which accompanies the DMA strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one machine cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset into the reset cycle |
| mode_i | input | 2 | Operating mode: 0 run, 1 pause, 2 load, 3 reset |
| irq_i | input | 1 | Interrupt request level |
| dma_in_req_i | input | 1 | DMA-in request level |
| dma_out_req_i | input | 1 | DMA-out request level |
| ie_i | input | 1 | Interrupt-enable bit from the datapath |
| op_hi_i | input | NIB_W | High opcode nibble, valid in a fetch cycle |
| op_lo_i | input | NIB_W | Low opcode nibble, valid in a fetch cycle |
| state_o | output | 3 | Current cycle: 0 reset, 1 init, 2 fetch, 3 execute, 4 DMA-in, 5 DMA-out, 6 interrupt |
| state_code_o | output | 2 | External state code |
| regs_clr_o | output | 1 | Reset-cycle register clear strobe |
| ptr_clr_o | output | 1 | Initialize-cycle selector and pointer-0 clear strobe |
| op_load_o | output | 1 | Latch opcode nibbles and step the program counter |
| dma_wr_o | output | 1 | Write external byte to memory at pointer 0 |
| dma_rd_o | output | 1 | Read memory at pointer 0 to the outside |
| dma_ptr_inc_o | output | 1 | Increment pointer 0 |
| ctx_save_o | output | 1 | Save context and redirect selectors for interrupt |

## Verification
The hardest condition to reach from the ports is a run request that the block must ignore because load came before it. It can only be produced by walking the mode pins through load and then run while execute is repeating. The stimulus then goes on to show that a pause in between turns the same run request into a fetch. The idle opcode is just as indirect: it shows only as an execute cycle that repeats, so the bench fetches 0x00, then 0x05 and 0x10, and wakes the idle loop with an interrupt and then with a DMA request.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_PAUSE = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_RESET = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_INIT    = 3'd1,
    ST_FETCH   = 3'd2,
    ST_EXEC    = 3'd3,
    ST_DMA_IN  = 3'd4,
    ST_DMA_OUT = 3'd5,
    ST_INTR    = 3'd6
  } cyc_state_e;

  // What the mode tracker decided to do at this edge
  typedef enum logic [2:0] {
    K_RESET,
    K_HOLD,
    K_LOAD,
    K_INIT,
    K_RESUME,
    K_RUN
  } step_e;

  localparam logic [1:0] SC_FETCH = 2'd0;
  localparam logic [1:0] SC_EXEC  = 2'd1;
  localparam logic [1:0] SC_DMA   = 2'd2;
  localparam logic [1:0] SC_INTR  = 2'd3;

  typedef struct packed {
    logic regs_clr;
    logic ptr_clr;
    logic op_load;
    logic dma_wr;
    logic dma_rd;
    logic dma_inc;
    logic ctx_save;
  } strobes_t;

endpackage

// File: rtl/mcs_mode_track.sv
module mcs_mode_track
  import mcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  output step_e      step_o,
  output logic       active_o
);

  mode_e eff_q, eff_d;
  logic  active_q;
  mode_e req;

  assign req = mode_e'(mode_i);

  always_comb begin
    eff_d  = eff_q;
    step_o = K_HOLD;
    case (req)
      MODE_RESET: begin eff_d = MODE_RESET; step_o = K_RESET; end
      MODE_PAUSE: begin eff_d = MODE_PAUSE; step_o = K_HOLD;  end
      MODE_LOAD:  begin eff_d = MODE_LOAD;  step_o = K_LOAD;  end
      default: begin
        case (eff_q)
          MODE_LOAD:  begin eff_d = MODE_LOAD; step_o = K_LOAD;   end
          MODE_RESET: begin eff_d = MODE_RUN;  step_o = K_INIT;   end
          MODE_PAUSE: begin eff_d = MODE_RUN;  step_o = K_RESUME; end
          default:    begin eff_d = MODE_RUN;  step_o = K_RUN;    end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q    <= MODE_RESET;
      active_q <= 1'b1;
    end else begin
      eff_q    <= eff_d;
      active_q <= (req != MODE_PAUSE);
    end
  end

  assign active_o = active_q;

  // R9: a run request that follows load is absorbed
  a_r9_load_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_q == MODE_LOAD && req == MODE_RUN) |-> step_o == K_LOAD);

endmodule

// File: rtl/mcs_arbiter.sv
module mcs_arbiter
  import mcs_pkg::*;
#(
  parameter int NREQ = 3
)(
  input  logic [NREQ-1:0]      req_i,
  input  logic [NREQ-1:0][2:0] tgt_i,
  input  cyc_state_e           fallback_i,
  output cyc_state_e           pick_o
);

  // index 0 is the most urgent request
  always_comb begin
    pick_o = fallback_i;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_i[i]) pick_o = cyc_state_e'(tgt_i[i]);
    end
  end

endmodule

// File: rtl/mcs_fsm.sv
module mcs_fsm
  import mcs_pkg::*;
#(
  parameter int NIB_W = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step_i,
  input  logic             irq_i,
  input  logic             dma_in_i,
  input  logic             dma_out_i,
  input  logic             ie_i,
  input  logic [NIB_W-1:0] op_hi_i,
  input  logic [NIB_W-1:0] op_lo_i,
  output cyc_state_e       state_o
);

  localparam int NREQ = 3;

  cyc_state_e cur_q, nxt, arb_pick, fb;
  logic       idle_q, idle_d;
  logic       use_arb, dma_ok, int_ok;
  logic [NREQ-1:0]      reqs;
  logic [NREQ-1:0][2:0] tgts;

  always_comb begin
    nxt     = cur_q;
    fb      = ST_FETCH;
    use_arb = 1'b0;
    dma_ok  = 1'b0;
    int_ok  = 1'b0;
    idle_d  = idle_q;
    case (step_i)
      K_RESET:  begin nxt = ST_RESET; idle_d = 1'b1; end
      K_HOLD:   nxt = cur_q;
      K_INIT:   nxt = ST_INIT;
      K_RESUME: nxt = ST_FETCH;
      K_LOAD: begin
        use_arb = 1'b1;
        dma_ok  = 1'b1;
        int_ok  = (cur_q != ST_INTR);
        fb      = ST_EXEC;
        idle_d  = 1'b1;
      end
      default: begin
        case (cur_q)
          ST_FETCH: begin
            nxt    = ST_EXEC;
            idle_d = (op_hi_i == '0) && (op_lo_i == '0);
          end
          ST_INIT: begin
            use_arb = 1'b1; dma_ok = 1'b1; fb = ST_FETCH;
          end
          ST_EXEC: begin
            use_arb = 1'b1; dma_ok = 1'b1; int_ok = 1'b1;
            fb = idle_q ? ST_EXEC : ST_FETCH;
          end
          ST_DMA_IN, ST_DMA_OUT: begin
            use_arb = 1'b1; dma_ok = 1'b1; int_ok = 1'b1; fb = ST_FETCH;
          end
          ST_INTR: begin
            use_arb = 1'b1; dma_ok = 1'b1; fb = ST_FETCH;
          end
          default: nxt = ST_INIT;
        endcase
      end
    endcase
  end

  assign reqs = {irq_i & ie_i & int_ok, dma_out_i & dma_ok, dma_in_i & dma_ok};
  assign tgts = {ST_INTR, ST_DMA_OUT, ST_DMA_IN};

  mcs_arbiter #(.NREQ(NREQ)) u_arb (
    .req_i      (reqs),
    .tgt_i      (tgts),
    .fallback_i (fb),
    .pick_o     (arb_pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= ST_RESET;
      idle_q <= 1'b1;
    end else begin
      cur_q  <= use_arb ? arb_pick : nxt;
      idle_q <= idle_d;
    end
  end

  assign state_o = cur_q;

  // R3: fetch always proceeds to execute in run
  a_r3_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == K_RUN && cur_q == ST_FETCH) |=> cur_q == ST_EXEC);

  // R4: DMA-in wins arbitration after execute, DMA and interrupt cycles
  a_r4_dma_in_first: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == K_RUN && dma_in_i &&
     (cur_q == ST_EXEC || cur_q == ST_DMA_IN || cur_q == ST_DMA_OUT || cur_q == ST_INTR))
    |=> cur_q == ST_DMA_IN);

  // R7: no interrupt cycle directly after another
  a_r7_no_double_int: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_INTR && step_i != K_HOLD) |=> cur_q != ST_INTR);

  // R8: load never reaches fetch
  a_r8_load_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == K_LOAD) |=> (cur_q != ST_FETCH && cur_q != ST_INIT && cur_q != ST_RESET));

  // R11: initialize never goes to interrupt
  a_r11_init_no_int: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == K_RUN && cur_q == ST_INIT) |=> (cur_q != ST_INTR && cur_q != ST_EXEC));

endmodule

// File: rtl/mcs_outdec.sv
module mcs_outdec
  import mcs_pkg::*;
(
  input  cyc_state_e state_i,
  input  logic       active_i,
  output logic [1:0] code_o,
  output strobes_t   stb_o
);

  strobes_t raw;

  always_comb begin
    raw    = '0;
    code_o = SC_EXEC;
    case (state_i)
      ST_RESET:   raw.regs_clr = 1'b1;
      ST_INIT:    raw.ptr_clr  = 1'b1;
      ST_FETCH:   begin code_o = SC_FETCH; raw.op_load = 1'b1; end
      ST_DMA_IN:  begin code_o = SC_DMA; raw.dma_wr = 1'b1; raw.dma_inc = 1'b1; end
      ST_DMA_OUT: begin code_o = SC_DMA; raw.dma_rd = 1'b1; raw.dma_inc = 1'b1; end
      ST_INTR:    begin code_o = SC_INTR; raw.ctx_save = 1'b1; end
      default:    code_o = SC_EXEC;
    endcase
  end

  assign stb_o = active_i ? raw : '0;

endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer
  import mcs_pkg::*;
#(
  parameter int NIB_W = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             irq_i,
  input  logic             dma_in_req_i,
  input  logic             dma_out_req_i,
  input  logic             ie_i,
  input  logic [NIB_W-1:0] op_hi_i,
  input  logic [NIB_W-1:0] op_lo_i,
  output logic [2:0]       state_o,
  output logic [1:0]       state_code_o,
  output logic             regs_clr_o,
  output logic             ptr_clr_o,
  output logic             op_load_o,
  output logic             dma_wr_o,
  output logic             dma_rd_o,
  output logic             dma_ptr_inc_o,
  output logic             ctx_save_o
);

  step_e      step;
  logic       active;
  cyc_state_e cur;
  strobes_t   stb;

  mcs_mode_track u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .step_o   (step),
    .active_o (active)
  );

  mcs_fsm #(.NIB_W(NIB_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .irq_i     (irq_i),
    .dma_in_i  (dma_in_req_i),
    .dma_out_i (dma_out_req_i),
    .ie_i      (ie_i),
    .op_hi_i   (op_hi_i),
    .op_lo_i   (op_lo_i),
    .state_o   (cur)
  );

  mcs_outdec u_dec (
    .state_i  (cur),
    .active_i (active),
    .code_o   (state_code_o),
    .stb_o    (stb)
  );

  assign state_o       = cur;
  assign regs_clr_o    = stb.regs_clr;
  assign ptr_clr_o     = stb.ptr_clr;
  assign op_load_o     = stb.op_load;
  assign dma_wr_o      = stb.dma_wr;
  assign dma_rd_o      = stb.dma_rd;
  assign dma_ptr_inc_o = stb.dma_inc;
  assign ctx_save_o    = stb.ctx_save;

  // R1: reset mode lands in the reset cycle with its clear strobe
  a_r1_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3) |=> (state_o == 3'd0 && regs_clr_o));

  // R10: pause freezes the cycle and silences every strobe
  a_r10_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1) |=> ($stable(state_o) &&
      {regs_clr_o, ptr_clr_o, op_load_o, dma_wr_o, dma_rd_o, dma_ptr_inc_o, ctx_save_o} == '0));

  // R6: the DMA pointer steps only in DMA-coded cycles
  a_r6_dma_code: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ptr_inc_o |-> (state_code_o == 2'd2 && (dma_wr_o ^ dma_rd_o)));

endmodule

// File: tb/mcycle_sequencer_bench.sv
`timescale 1ns/1ps
module mcycle_sequencer_bench;

  localparam int NIB_W = 4;
  localparam logic [1:0] M_RUN = 2'd0, M_PAUSE = 2'd1, M_LOAD = 2'd2, M_RST = 2'd3;
  localparam int S_RESET = 0, S_INIT = 1, S_FETCH = 2, S_EXEC = 3,
                 S_DIN = 4, S_DOUT = 5, S_INT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = M_RST;
  logic irq = 0, dmi = 0, dmo = 0, ie = 0;
  logic [NIB_W-1:0] op_hi = '0, op_lo = '0;
  logic [2:0] state;
  logic [1:0] code;
  logic regs_clr, ptr_clr, op_load, dma_wr, dma_rd, dma_inc, ctx_save;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mcycle_sequencer #(.NIB_W(NIB_W)) u_mcycle_sequencer (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .irq_i(irq),
    .dma_in_req_i(dmi), .dma_out_req_i(dmo), .ie_i(ie),
    .op_hi_i(op_hi), .op_lo_i(op_lo),
    .state_o(state), .state_code_o(code),
    .regs_clr_o(regs_clr), .ptr_clr_o(ptr_clr), .op_load_o(op_load),
    .dma_wr_o(dma_wr), .dma_rd_o(dma_rd), .dma_ptr_inc_o(dma_inc),
    .ctx_save_o(ctx_save)
  );

  function automatic logic [1:0] exp_code(int st);
    case (st)
      S_FETCH:      return 2'd0;
      S_DIN, S_DOUT: return 2'd2;
      S_INT:        return 2'd3;
      default:      return 2'd1;
    endcase
  endfunction

  // order: regs_clr ptr_clr op_load dma_wr dma_rd dma_inc ctx_save
  function automatic logic [6:0] exp_stb(int st);
    case (st)
      S_RESET: return 7'b1000000;
      S_INIT:  return 7'b0100000;
      S_FETCH: return 7'b0010000;
      S_DIN:   return 7'b0001010;
      S_DOUT:  return 7'b0000110;
      S_INT:   return 7'b0000001;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_cyc(string req, int st);
    chk({req, " state"}, int'(state), st);
    chk({req, " code"}, int'(code), int'(exp_code(st)));
    chk({req, " strobes"},
        int'({regs_clr, ptr_clr, op_load, dma_wr, dma_rd, dma_inc, ctx_save}),
        int'(exp_stb(st)));
  endtask

  task automatic t_reset_state();
    chk_cyc("R1 under rst_n", S_RESET);
    rst_n = 1'b1;
    mode = M_RST; tick();
    chk_cyc("R1 reset mode", S_RESET);
  endtask

  task automatic t_init_path();
    mode = M_RUN; op_hi = 4'h7; op_lo = 4'hA;
    tick(); chk_cyc("R2 init after reset", S_INIT);
    tick(); chk_cyc("R12 first fetch", S_FETCH);
    tick(); chk_cyc("R3 execute after fetch", S_EXEC);
    tick(); chk_cyc("R3 next fetch", S_FETCH);
  endtask

  task automatic t_init_dma();
    mode = M_RST; tick();
    mode = M_RUN; dmi = 1;
    tick(); chk_cyc("R11 init", S_INIT);
    tick(); chk_cyc("R11 init to dma-in R6", S_DIN);
    dmi = 0; dmo = 1;
    tick(); chk_cyc("R6 dma-out", S_DOUT);
    dmo = 0;
    tick(); chk_cyc("R11 fetch after dma", S_FETCH);
  endtask

  task automatic t_priority();
    op_hi = 4'hF; op_lo = 4'h4;
    dmi = 1; dmo = 1; irq = 1; ie = 1;
    tick(); chk_cyc("R3 fetch ignores requests", S_EXEC);
    tick(); chk_cyc("R4 dma-in first", S_DIN);
    tick(); chk_cyc("R4 dma-in repeats", S_DIN);
    dmi = 0;
    tick(); chk_cyc("R4 dma-out second", S_DOUT);
    dmo = 0;
    tick(); chk_cyc("R4 interrupt third", S_INT);
    tick(); chk_cyc("R7 no second interrupt", S_FETCH);
    irq = 0; ie = 0;
  endtask

  task automatic t_irq_masked();
    irq = 1; ie = 0; op_hi = 4'h3; op_lo = 4'h1;
    tick(); chk_cyc("R7 masked exec", S_EXEC);
    tick(); chk_cyc("R7 masked irq ignored", S_FETCH);
    ie = 1;
    tick(); chk_cyc("R7 exec", S_EXEC);
    tick(); chk_cyc("R7 enabled irq taken", S_INT);
    dmo = 1;
    tick(); chk_cyc("R7 interrupt then dma", S_DOUT);
    dmo = 0; irq = 0;
    tick(); chk_cyc("R7 back to fetch", S_FETCH);
    ie = 0;
  endtask

  task automatic t_idle();
    op_hi = 4'h0; op_lo = 4'h0;
    tick(); chk_cyc("R5 idle exec", S_EXEC);
    tick(); chk_cyc("R5 idle holds", S_EXEC);
    tick(); chk_cyc("R5 idle holds again", S_EXEC);
    irq = 1;
    tick(); chk_cyc("R5 masked irq keeps idle", S_EXEC);
    ie = 1;
    tick(); chk_cyc("R5 irq wakes idle", S_INT);
    irq = 0; ie = 0;
    tick(); chk_cyc("R5 fetch after wake", S_FETCH);
    tick(); chk_cyc("R5 idle exec 2", S_EXEC);
    dmi = 1;
    tick(); chk_cyc("R5 dma wakes idle", S_DIN);
    dmi = 0; op_hi = 4'h0; op_lo = 4'h5;
    tick(); chk_cyc("R5 fetch", S_FETCH);
    tick(); chk_cyc("R5 op 05 exec", S_EXEC);
    tick(); chk_cyc("R5 op 05 not idle", S_FETCH);
    op_hi = 4'h1; op_lo = 4'h0;
    tick(); tick(); chk_cyc("R5 op 10 not idle", S_FETCH);
  endtask

  task automatic t_load();
    mode = M_LOAD;
    tick(); chk_cyc("R8 load enters exec", S_EXEC);
    tick(); chk_cyc("R8 load sits", S_EXEC);
    dmi = 1;
    tick(); chk_cyc("R8 load dma-in", S_DIN);
    dmi = 0;
    tick(); chk_cyc("R8 back to exec", S_EXEC);
    dmo = 1;
    tick(); chk_cyc("R8 load dma-out", S_DOUT);
    dmo = 0;
    tick(); chk_cyc("R8 exec after dma-out", S_EXEC);
    irq = 1; ie = 1;
    tick(); chk_cyc("R8 load interrupt", S_INT);
    irq = 0; ie = 0;
    tick(); chk_cyc("R8 exec after interrupt", S_EXEC);
    mode = M_RUN;
    tick(); chk_cyc("R9 run ignored", S_EXEC);
    tick(); chk_cyc("R9 still load", S_EXEC);
    mode = M_PAUSE;
    tick(); chk("R10 pause in load state", int'(state), S_EXEC);
    mode = M_RUN;
    tick(); chk_cyc("R9 run after pause fetches", S_FETCH);
  endtask

  task automatic t_pause();
    mode = M_RST; tick();
    mode = M_RUN;
    tick(); chk_cyc("R10 init", S_INIT);
    tick(); chk_cyc("R10 fetch", S_FETCH);
    mode = M_PAUSE;
    tick();
    chk("R10 paused state", int'(state), S_FETCH);
    chk("R10 paused strobes",
        int'({regs_clr, ptr_clr, op_load, dma_wr, dma_rd, dma_inc, ctx_save}), 0);
    dmi = 1;
    tick();
    chk("R10 pause ignores dma", int'(state), S_FETCH);
    chk("R10 still silent",
        int'({regs_clr, ptr_clr, op_load, dma_wr, dma_rd, dma_inc, ctx_save}), 0);
    dmi = 0; mode = M_RUN; op_hi = 4'h7; op_lo = 4'h7;
    tick(); chk_cyc("R10 resume at fetch", S_FETCH);
    tick(); chk_cyc("R10 exec after resume", S_EXEC);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset_state();
    t_init_path();
    t_init_dma();
    t_priority();
    t_irq_masked();
    t_idle();
    t_load();
    t_pause();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule